// File: doc/BRIEF.md
# Multiplexed ADC serial host controller

This block is the host-side master for a 10-bit serial analog-to-digital converter with a multiplexed analog input. A user asks for a conversion by presenting a 4-bit channel address with a request strobe. The block then runs one 10-clock serial frame on the converter pins. It drives the channel address out on the first four I/O clocks, most significant bit first. In the same frame it shifts in the ten result bits, which belong to the conversion started by the frame before.

After the tenth clock the converter is busy converting and holds its end-of-conversion line low. The block will not take a new request until that line has gone low and then returned high. Each frame ends with a one-cycle done pulse. The pulse carries the captured word and the channel address that produced it. Because no conversion exists before the first frame after reset, the first word is marked stale.

Two framing modes are chosen for each request. In framed mode, chip select falls before every frame and rises after it. In continuous mode, chip select comes out of reset high and stays low once the first frame has pulled it down. The block waits a setup interval whenever chip select has just fallen. The I/O clock half-period and the setup interval are parameter counts of the system clock.

Top module: `adc_mux_host`

## Requirements
- R1: After reset, chip select is high (inactive), the I/O clock is low, the request ready output is high and the done pulse is low.
- R2: Every accepted request produces exactly 10 rising I/O clock edges, all while chip select is low.
- R3: The channel address goes out MSB first. Address bit 3 is valid at the first rising I/O clock edge, bit 2 at the second, bit 1 at the third and bit 0 at the fourth. The address line changes only while the I/O clock is low, and it drives 0 for clocks 5 to 10.
- R4: The data line is sampled once for each rising I/O clock edge. The first sample is bit 9 of the result word and the tenth sample is bit 0.
- R5: The done pulse reports the channel address of the frame before. On the first result after reset, the stale flag is 1 and the reported channel is 0. After that the stale flag is 0.
- R6: When chip select falls, at least SETUP_CNT system clocks pass before the first rising I/O clock edge.
- R7: Inside a frame, every high phase of the I/O clock lasts exactly HALF_CNT system clocks. Every low phase between two rising edges also lasts exactly HALF_CNT system clocks.
- R8: After a frame, ready stays low until end-of-conversion has been seen low and then high. Ready is never high while end-of-conversion is low.
- R9: After a framed-mode frame, chip select returns high. After a continuous-mode frame (framed input 0), it stays low.
- R10: The done pulse lasts one system clock. It rises in the cycle after the tenth falling I/O clock edge is driven, and it fires once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and converter not busy |
| req_chan | input | 4 | Channel address for the new conversion |
| req_framed | input | 1 | 1: frame with chip select; 0: keep chip select low |
| res_valid | output | 1 | One-cycle done pulse |
| res_data | output | 10 | Result word of the previous conversion |
| res_chan | output | 4 | Channel address that produced res_data |
| res_stale | output | 1 | Result has no prior conversion behind it |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_clk | output | 1 | Converter I/O clock |
| adc_addr | output | 1 | Serial address to the converter |
| adc_data | input | 1 | Serial result from the converter |
| adc_eoc | input | 1 | End-of-conversion, low while converting |

## Verification
The assertions assume that end-of-conversion is high whenever the block is idle. They also assume the converter pulls it low soon after the tenth I/O clock. If the converter never pulls it low, the block waits forever. The bench's converter model gives these guarantees: end-of-conversion is high out of reset, goes low one cycle after the tenth falling clock, and returns high after a fixed conversion time. The model also changes its data bit only after a falling edge, which needs HALF_CNT of at least 2. The random stimulus changes only the channel and the framing mode, and it issues requests only while ready is high.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

  localparam int unsigned DATA_W     = 10;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned FRAME_CLKS = 10;
  localparam int unsigned IDX_W      = $clog2(FRAME_CLKS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_EOC_LO,
    ST_EOC_HI
  } host_state_t;

  // address bit placed on the line before clock (idx+1); zero past the field
  function automatic logic addr_bit_at(input logic [ADDR_W-1:0] ch,
                                       input logic [IDX_W-1:0]  idx);
    logic b;
    b = 1'b0;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      if (idx == IDX_W'(i)) b = ch[ADDR_W-1-i];
    end
    return b;
  endfunction

  // MSB-first serial accumulation
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] w,
                                                 input logic              b);
    return {w[DATA_W-2:0], b};
  endfunction

endpackage

// File: rtl/adc_tick_timer.sv
module adc_tick_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  // tick comes load_val cycles after the load, so the caller acts on the next edge
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val - 1'b1;
      run <= 1'b1;
    end else if (tick) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
  import adc_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_chan,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdata,
  output logic              addr_bit,
  output logic [DATA_W-1:0] rx_word,
  output logic [IDX_W-1:0]  bit_idx,
  output logic [ADDR_W-1:0] frame_chan
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx    <= IDX_W'(FRAME_CLKS);
      frame_chan <= '0;
      rx_word    <= '0;
    end else begin
      if (start) begin
        bit_idx    <= '0;
        frame_chan <= start_chan;
      end else if (fall) begin
        bit_idx <= bit_idx + 1'b1;
      end
      if (rise) rx_word <= shift_in(rx_word, sdata);
    end
  end

  // the index moves only on a falling edge, so the line is steady through each high phase
  assign addr_bit = addr_bit_at(frame_chan, bit_idx);
endmodule

// File: rtl/adc_mux_host.sv
module adc_mux_host
  import adc_mux_pkg::*;
#(
  parameter int unsigned HALF_CNT  = 4,
  parameter int unsigned SETUP_CNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic              req_framed,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [ADDR_W-1:0] res_chan,
  output logic              res_stale,
  output logic              adc_cs_n,
  output logic              adc_clk,
  output logic              adc_addr,
  input  logic              adc_data,
  input  logic              adc_eoc
);
  localparam int unsigned MAX_CNT = (HALF_CNT > SETUP_CNT) ? HALF_CNT : SETUP_CNT;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  host_state_t       state;
  logic              framed_q;
  logic              have_prev;
  logic [ADDR_W-1:0] prev_chan;
  logic [DATA_W-1:0] rx_word;
  logic [IDX_W-1:0]  bit_idx;
  logic [ADDR_W-1:0] frame_chan;
  logic              tick;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  // named events, also watched by the checker
  logic frame_start, rise, fall, last_bit, frame_end;

  assign req_ready   = (state == ST_IDLE);
  assign frame_start = req_ready && req_valid;
  assign rise        = ((state == ST_SETUP) || (state == ST_LOW)) && tick;
  assign fall        = (state == ST_HIGH) && tick;
  assign last_bit    = (bit_idx == IDX_W'(FRAME_CLKS - 1));
  assign frame_end   = fall && last_bit;

  // the setup wait applies only when chip select is about to fall
  assign tmr_load = frame_start || rise || (fall && !last_bit);
  assign tmr_val  = (frame_start && adc_cs_n) ? CNT_W'(SETUP_CNT) : CNT_W'(HALF_CNT);

  adc_tick_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick)
  );

  adc_frame_shifter i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .start_chan (req_chan),
    .rise       (rise),
    .fall       (fall),
    .sdata      (adc_data),
    .addr_bit   (adc_addr),
    .rx_word    (rx_word),
    .bit_idx    (bit_idx),
    .frame_chan (frame_chan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      adc_cs_n  <= 1'b1;
      adc_clk   <= 1'b0;
      framed_q  <= 1'b1;
      have_prev <= 1'b0;
      prev_chan <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      res_stale <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            framed_q <= req_framed;
            adc_cs_n <= 1'b0;
            state    <= adc_cs_n ? ST_SETUP : ST_LOW;
          end
        end
        ST_SETUP, ST_LOW: begin
          if (tick) begin
            adc_clk <= 1'b1;
            state   <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            adc_clk <= 1'b0;
            if (last_bit) begin
              res_valid <= 1'b1;
              res_data  <= rx_word;
              res_chan  <= prev_chan;
              res_stale <= !have_prev;
              prev_chan <= frame_chan;
              have_prev <= 1'b1;
              adc_cs_n  <= framed_q;
              state     <= ST_EOC_LO;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_EOC_LO: if (!adc_eoc) state <= ST_EOC_HI;
        ST_EOC_HI: if (adc_eoc)  state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_mux_host_chk.sv
module adc_mux_host_chk #(
  parameter int unsigned HALF_CNT  = 4,
  parameter int unsigned SETUP_CNT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic adc_cs_n,
  input logic adc_clk,
  input logic adc_addr,
  input logic adc_eoc,
  input logic req_ready,
  input logic res_valid,
  input logic frame_end
);
  logic [15:0] hi_run;
  logic [15:0] cs_lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run    <= '0;
      cs_lo_run <= '0;
    end else begin
      hi_run    <= !adc_clk ? 16'd0 : (hi_run == 16'hFFFF ? hi_run : hi_run + 16'd1);
      cs_lo_run <= adc_cs_n ? 16'd0 : (cs_lo_run == 16'hFFFF ? cs_lo_run : cs_lo_run + 16'd1);
    end
  end

  // R7
  hi_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_clk) |-> hi_run == 16'(HALF_CNT));

  // R6
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_clk) |-> cs_lo_run >= 16'(SETUP_CNT));

  // R2
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk |-> !adc_cs_n);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk |-> $stable(adc_addr));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !req_ready);

  // R8
  ready_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_eoc);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> res_valid);
endmodule

bind adc_mux_host adc_mux_host_chk #(
  .HALF_CNT  (HALF_CNT),
  .SETUP_CNT (SETUP_CNT)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_cs_n  (adc_cs_n),
  .adc_clk   (adc_clk),
  .adc_addr  (adc_addr),
  .adc_eoc   (adc_eoc),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .frame_end (frame_end)
);

// File: tb/test_adc_mux_host.sv
module test_adc_mux_host;
  localparam int HALF  = 3;
  localparam int SETUP = 5;
  localparam int CONV  = 12;
  localparam logic [9:0] INIT_WORD = 10'h2A5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [3:0] req_chan;
  logic       req_framed;
  logic       res_valid;
  logic [9:0] res_data;
  logic [3:0] res_chan;
  logic       res_stale;
  logic       adc_cs_n, adc_clk, adc_addr, adc_data, adc_eoc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  adc_mux_host #(.HALF_CNT(HALF), .SETUP_CNT(SETUP)) i_adc_mux_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_framed(req_framed), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan), .res_stale(res_stale),
    .adc_cs_n(adc_cs_n), .adc_clk(adc_clk), .adc_addr(adc_addr),
    .adc_data(adc_data), .adc_eoc(adc_eoc)
  );

  function automatic logic [9:0] conv_fn(input logic [3:0] a);
    return 10'((int'(a) * 61 + 7) % 1024);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: samples address on rises, moves data after falls
  logic       m_clk_q;
  int         m_rise, m_fall, m_conv;
  logic [3:0] m_addr;
  logic [9:0] m_word;
  logic       m_eoc;

  assign adc_data = (m_fall < 10) ? m_word[9 - m_fall] : 1'b0;
  assign adc_eoc  = m_eoc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk_q <= 1'b0; m_rise <= 0; m_fall <= 0; m_conv <= 0;
      m_addr <= 4'd0; m_word <= INIT_WORD; m_eoc <= 1'b1;
    end else begin
      m_clk_q <= adc_clk;
      if (adc_clk && !m_clk_q) begin
        if (m_rise < 4) m_addr <= {m_addr[2:0], adc_addr};
        m_rise <= m_rise + 1;
      end
      if (!adc_clk && m_clk_q) begin
        m_fall <= m_fall + 1;
        if (m_fall == 9) begin m_eoc <= 1'b0; m_conv <= CONV; end
      end
      if (m_conv > 0) begin
        m_conv <= m_conv - 1;
        if (m_conv == 1) begin
          m_eoc <= 1'b1; m_word <= conv_fn(m_addr); m_fall <= 0; m_rise <= 0;
        end
      end
    end
  end

  // pin-level phase monitor
  int   hi_len, lo_len, cs_lo_len, nrise;
  logic clk_prev, cs_prev, setup_pend;

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_len = 0; lo_len = 0; cs_lo_len = 0; nrise = 0;
      clk_prev = 1'b0; cs_prev = 1'b1; setup_pend = 1'b0;
    end else begin
      if (adc_clk) begin
        if (!clk_prev) begin
          // R7 low phase between rises
          if (nrise > 0) chk(lo_len == HALF, "R7 low phase", lo_len, HALF);
          // R6 setup after chip select fall
          if (setup_pend) begin
            chk(cs_lo_len >= SETUP, "R6 setup", cs_lo_len, SETUP);
            setup_pend = 1'b0;
          end
          // R2 clock only inside chip select
          chk(!adc_cs_n, "R2 cs during clock", adc_cs_n, 0);
          nrise++;
          hi_len = 1;
        end else hi_len++;
      end else begin
        if (clk_prev) begin
          chk(hi_len == HALF, "R7 high phase", hi_len, HALF);
          lo_len = 1;
        end else lo_len++;
      end
      if (!adc_cs_n) begin
        if (cs_prev) begin cs_lo_len = 1; setup_pend = 1'b1; end
        else cs_lo_len++;
      end
      if (res_valid) begin
        chk(nrise == 10, "R2 rises per frame", nrise, 10);
        nrise = 0;
      end
      clk_prev = adc_clk;
      cs_prev  = adc_cs_n;
    end
  end

  logic [3:0] last_chan;
  bit         have_last;

  task automatic run_frame(input logic fr, input logic [3:0] ch);
    int  n;
    bit  saw_low;
    logic [9:0] exp_data;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_framed = fr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 2000) begin @(negedge clk); n++; end
    chk(res_valid, "R10 done seen", res_valid, 1);
    exp_data = have_last ? conv_fn(last_chan) : INIT_WORD;
    // R4 data MSB first, previous conversion
    chk(res_data == exp_data, "R4 data", res_data, exp_data);
    // R5 channel and stale flag
    chk(res_stale == !have_last, "R5 stale", res_stale, !have_last);
    chk(res_chan == (have_last ? last_chan : 4'd0), "R5 chan", res_chan,
        have_last ? last_chan : 4'd0);
    // R3 address seen by the converter
    chk(m_addr == ch, "R3 address", m_addr, ch);
    @(negedge clk);
    chk(!res_valid, "R10 one cycle", res_valid, 0);
    chk(!req_ready, "R8 busy after frame", req_ready, 0);
    // R9 chip select after the frame
    chk(adc_cs_n == fr, "R9 cs after frame", adc_cs_n, fr);
    saw_low = 1'b0;
    n = 0;
    while (!req_ready && n < 2000) begin
      if (!adc_eoc) begin
        saw_low = 1'b1;
        chk(!req_ready, "R8 ready while eoc low", req_ready, 0);
      end
      @(negedge clk); n++;
    end
    chk(saw_low, "R8 eoc cycle before ready", saw_low, 1);
    chk(adc_eoc, "R8 eoc high at ready", adc_eoc, 1);
    last_chan = ch; have_last = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_chan = 4'd0; req_framed = 1'b1;
    have_last = 1'b0; last_chan = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
    chk(adc_clk == 1'b0, "R1 clk", adc_clk, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1 done", res_valid, 0);
    // directed corners: extreme channels, mode changes both ways
    run_frame(1'b1, 4'hF);
    run_frame(1'b1, 4'h0);
    run_frame(1'b0, 4'hA);
    run_frame(1'b0, 4'h5);
    run_frame(1'b1, 4'h9);
    run_frame(1'b0, 4'h6);
    for (int i = 0; i < 30; i++) begin
      run_frame(1'($urandom % 2), 4'($urandom % 16));
    end
    run_frame(1'b1, 4'h3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule